// File: doc/BRIEF.md
# Serial DAC Input Interface

This block is the digital front end of a current-output DAC. It listens to a three-wire serial port: an active-low frame select, a serial clock and a data line. All three are sampled by a faster system clock. Each frame is 16 bits long and is shifted into an input register. When the frame select returns high, a two-bit command at the head of the frame decides what happens next. The command can load the data field into the DAC code register, or it can move data capture to the rising serial-clock edge.

The data shifted out of the top of the input register is driven on a serial output, so that several converters can share one chain. The code width is a parameter. It is 14 bits by default. It may be set to 12 bits, and in that case the two lowest frame bits are dropped. A one-cycle update strobe marks every new code, and a one-cycle error strobe marks a frame that was not 16 bits long. The system clock must run at least four times faster than the serial clock.

Top module: `serdac_rx`

## Requirements
- R1: After reset, code_o is 0, sdo_o is 0, and data is captured on the falling serial-clock edge.
- R2: A frame is sent MSB first. Bits 15:14 hold the command. Command 00 copies frame bits 13:0 to code_o at the rising edge of frame_ni, and the copy happens only if exactly 16 capture edges came since the falling edge of frame_ni.
- R3: With DATA_W = 12, code_o takes frame bits 13:2, and frame bits 1:0 are ignored.
- R4: Commands 01 and 10 leave code_o unchanged and raise no strobe.
- R5: Command 11 moves capture to the rising edge of sclk_i and leaves code_o unchanged. The next command 00 frame, captured on rising edges, loads normally.
- R6: A further command 11 frame keeps rising-edge capture. Only reset brings back falling-edge capture.
- R7: While frame_ni is high, sclk_i and sdin_i have no effect on the input register, sdo_o or code_o.
- R8: A frame with fewer or more than 16 capture edges leaves code_o unchanged and pulses err_o for one cycle.
- R9: sdo_o shows the top bit of the input register and changes only on the serial-clock edge opposite to capture. During a frame, the bits read before each capture edge are the previous 16-bit frame, MSB first.
- R10: If the last opposite edge and the rising edge of frame_ni arrive together, both the code load and the serial-output shift take effect.
- R11: upd_o is high for exactly one cycle each time code_o takes a new value, and code_o never changes without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock |
| sdin_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, for chaining |
| code_o | output | DATA_W | DAC code register |
| upd_o | output | 1 | One-cycle strobe on a code load |
| err_o | output | 1 | One-cycle strobe on a bad frame length |

## Verification
Two events can fall in the same system-clock cycle: the shift of the serial output on the last opposite edge, and the decision taken when the frame closes. The bench provokes this by raising frame_ni in the very step that returns sclk_i to idle after the sixteenth bit. Both land in the same synchronizer cycle. The case is judged correct only if the code loads with a single strobe and sdo_o then shows the frame's own MSB. A design that gates the output shift on the current frame state loses that shift, and the check catches it.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  typedef enum logic [1:0] {
    CMD_LOAD = 2'b00,
    CMD_RSV1 = 2'b01,
    CMD_RSV2 = 2'b10,
    CMD_RISE = 2'b11
  } cmd_e;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int unsigned   W       = 3,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else             stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/serdac_shift.sv
module serdac_shift #(
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_s_i,
  input  logic               fr_s_i,
  input  logic               din_s_i,
  input  logic               rise_mode_i,
  output logic [FRAME_W-1:0] sreg_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               fr_rise_o,
  output logic               fr_hi_q_o,
  output logic               sdo_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

  logic sclk_q, fr_q;
  logic sclk_rise, sclk_fall, fr_fall;
  logic cap_edge, out_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      fr_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      fr_q   <= fr_s_i;
    end
  end

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign sclk_fall = ~sclk_s_i & sclk_q;
  assign fr_fall   = ~fr_s_i & fr_q;
  assign fr_rise_o = fr_s_i & ~fr_q;
  assign fr_hi_q_o = fr_q;

  // capture gated by live frame level, output shift by the previous one,
  // so an output edge coinciding with frame close still counts
  assign cap_edge = (rise_mode_i ? sclk_rise : sclk_fall) & ~fr_s_i;
  assign out_edge = (rise_mode_i ? sclk_fall : sclk_rise) & ~fr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_o <= '0;
      cnt_o  <= '0;
      sdo_o  <= 1'b0;
    end else begin
      if (cap_edge) sreg_o <= {sreg_o[FRAME_W-2:0], din_s_i};
      if (fr_fall)
        cnt_o <= cap_edge ? CNT_W'(1) : '0;
      else if (cap_edge && cnt_o != CNT_MAX)
        cnt_o <= cnt_o + CNT_W'(1);
      if (out_edge) sdo_o <= sreg_o[FRAME_W-1];
    end
  end
endmodule

// File: rtl/serdac_ctl.sv
module serdac_ctl
  import serdac_pkg::*;
#(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned DATA_W  = 14,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 2),
  localparam int unsigned TOP    = FRAME_W - 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fr_rise_i,
  input  logic [FRAME_W-1:0] sreg_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [DATA_W-1:0]  code_o,
  output logic               upd_o,
  output logic               err_o,
  output logic               rise_mode_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  cmd_e cmd;
  logic full;

  assign cmd  = cmd_e'(sreg_i[FRAME_W-1 -: 2]);
  assign full = (cnt_i == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o      <= '0;
      upd_o       <= 1'b0;
      err_o       <= 1'b0;
      rise_mode_o <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      err_o <= 1'b0;
      if (fr_rise_i) begin
        if (!full) begin
          err_o <= 1'b1;
        end else begin
          unique case (cmd)
            CMD_LOAD: begin
              code_o <= sreg_i[TOP -: DATA_W];
              upd_o  <= 1'b1;
            end
            CMD_RISE: rise_mode_o <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/serdac_rx.sv
module serdac_rx #(
  parameter int unsigned FRAME_W    = 16,
  parameter int unsigned DATA_W     = 14,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic              sdo_o,
  output logic [DATA_W-1:0] code_o,
  output logic              upd_o,
  output logic              err_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2);

  logic [2:0]         pins_s;
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;
  logic               fr_rise, fr_hi_q, rise_mode;

  serdac_sync #(
    .W(3), .STAGES(SYNC_STAGE), .RST_VAL(3'b011)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdin_i, frame_ni, sclk_i}),
    .q_o   (pins_s)
  );

  serdac_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (pins_s[0]),
    .fr_s_i     (pins_s[1]),
    .din_s_i    (pins_s[2]),
    .rise_mode_i(rise_mode),
    .sreg_o     (sreg),
    .cnt_o      (cnt),
    .fr_rise_o  (fr_rise),
    .fr_hi_q_o  (fr_hi_q),
    .sdo_o      (sdo_o)
  );

  serdac_ctl #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fr_rise_i  (fr_rise),
    .sreg_i     (sreg),
    .cnt_i      (cnt),
    .code_o     (code_o),
    .upd_o      (upd_o),
    .err_o      (err_o),
    .rise_mode_o(rise_mode)
  );
endmodule

// File: rtl/serdac_rx_chk.sv
module serdac_rx_chk #(
  parameter int unsigned DATA_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_i,
  input logic              err_i,
  input logic [DATA_W-1:0] code_i,
  input logic              sdo_i,
  input logic              fr_rise_i,
  input logic              fr_hi_q_i
);
  // R11
  upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !upd_i);

  // R11
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |-> code_i == $past(code_i));

  // R8
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> !err_i);

  // R8
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_i && upd_i));

  // R2
  upd_at_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> $past(fr_rise_i));

  // R7
  sdo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fr_hi_q_i) |-> $stable(sdo_i));
endmodule

bind serdac_rx serdac_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .upd_i    (upd_o),
  .err_i    (err_o),
  .code_i   (code_o),
  .sdo_i    (sdo_o),
  .fr_rise_i(fr_rise),
  .fr_hi_q_i(fr_hi_q)
);

// File: tb/serdac_rx_tb_top.sv
module serdac_rx_tb_top;
  localparam int HALF = 6;
  localparam int GAP  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic sdo, upd, err, sdo12, upd12, err12;
  logic [13:0] code;
  logic [11:0] code12;

  always #10 clk = ~clk;

  serdac_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(fr_n), .sclk_i(sclk), .sdin_i(din),
    .sdo_o(sdo), .code_o(code), .upd_o(upd), .err_o(err));

  serdac_rx #(.DATA_W(12)) dut12_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(fr_n), .sclk_i(sclk), .sdin_i(din),
    .sdo_o(sdo12), .code_o(code12), .upd_o(upd12), .err_o(err12));

  int n_chk = 0, n_err = 0;
  int err_seen = 0, err_exp = 0;
  bit rm = 1'b0, done = 1'b0;
  logic [13:0] exp14 = '0;
  logic [11:0] exp12 = '0;
  logic [15:0] prev_w = '0;
  bit prev_ok = 1'b1;
  logic [13:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (err) err_seen++;
      if (upd) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_err++;
          $display("FAIL R11: actual=%0h expected=no update", code);
        end else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          if (code !== e) begin
            n_err++;
            $display("FAIL R2: actual=%0h expected=%0h", code, e);
          end
        end
      end
    end
  end

  task automatic do_reset();
    fr_n = 1'b1; sclk = 1'b1; din = 1'b0; rst_n = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    rm = 1'b0; exp14 = '0; exp12 = '0; prev_w = '0; prev_ok = 1'b1;
    exp_q.delete();
  endtask

  task automatic frame_checks();
    chk(code == exp14, "R2", 32'(code), 32'(exp14));
    chk(code12 == exp12, "R3", 32'(code12), 32'(exp12));
    chk(err_seen == err_exp, "R8", 32'(err_seen), 32'(err_exp));
    chk(exp_q.size() == 0, "R11", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic send(input logic [15:0] w, input int nb, input bit coin, input string req);
    logic [15:0] seen;
    seen = '0;
    sclk = rm ? 1'b0 : 1'b1;
    wait_n(HALF);
    fr_n = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < nb; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      wait_n(HALF);
      if (i < 16) seen[15-i] = sdo;
      sclk = ~sclk;
      wait_n(HALF);
      sclk = ~sclk;
      if (coin && i == nb - 1) fr_n = 1'b1;
      else wait_n(HALF);
    end
    fr_n = 1'b1;
    if (nb >= 16 && prev_ok) chk(seen == prev_w, "R9", 32'(seen), 32'(prev_w));
    if (nb == 16) begin
      prev_w = w; prev_ok = 1'b1;
      if (w[15:14] == 2'b00) begin
        exp14 = w[13:0]; exp12 = w[13:2]; exp_q.push_back(w[13:0]);
      end else if (w[15:14] == 2'b11) begin
        rm = 1'b1;
      end
    end else begin
      prev_ok = 1'b0; err_exp++;
    end
    wait_n(GAP);
    if (nb == 16) chk(sdo == w[15], coin ? "R10" : "R9", 32'(sdo), 32'(w[15]));
    frame_checks();
    if (req != "") chk(code == exp14, req, 32'(code), 32'(exp14));
  endtask

  initial begin
    do_reset();
    // R1
    chk(code == 14'd0, "R1", 32'(code), 0);
    chk(sdo == 1'b0, "R1", 32'(sdo), 0);
    chk(upd == 1'b0 && err == 1'b0, "R1", 32'({upd, err}), 0);
    send(16'h1ABC, 16, 1'b0, "R2");
    send(16'h3FFF, 16, 1'b0, "R3");
    send(16'h0003, 16, 1'b0, "R3");
    send(16'h4123, 16, 1'b0, "R4");
    send(16'h8456, 16, 1'b0, "R4");
    begin : idle_toggle // R7
      logic s0;
      s0 = sdo;
      for (int k = 0; k < 12; k++) begin
        din = k[0]; sclk = ~sclk; wait_n(HALF);
      end
      sclk = 1'b1; wait_n(GAP);
      chk(sdo == s0, "R7", 32'(sdo), 32'(s0));
      chk(code == exp14, "R7", 32'(code), 32'(exp14));
    end
    send(16'h2A55, 16, 1'b0, "R7");
    send(16'h0FFF, 15, 1'b0, "R8");
    send(16'h0AAA, 17, 1'b0, "R8");
    send(16'h0005, 16, 1'b0, "R8");
    send(16'h1C3A, 16, 1'b1, "R10");
    send(16'hC000, 16, 1'b0, "R5");
    send(16'h2222, 16, 1'b0, "R5");
    send(16'hFFFF, 16, 1'b0, "R6");
    send(16'h1357, 16, 1'b1, "R6");
    do_reset();
    chk(code == 14'd0 && code12 == 12'd0, "R1", 32'(code), 0);
    send(16'h0F0F, 16, 1'b0, "R6");
    send(16'h3001, 16, 1'b0, "R9");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule